// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Front End

This block is the host-facing port of a display controller. An external processor reaches it over an 8-bit parallel bus. The bus runs in one of two timing styles, chosen by a static mode input.

- **Split-strobe style:** separate active-low read and write strobes.
- **Enable-strobe style:** a direction level plus an active-high enable that clocks each transfer.

Two chip-select pins of opposite polarity gate all activity. An address bit marks each byte as either a command or display data.

All bus pins are asynchronous to the internal clock. They pass through a synchronizer, and strobe edges are found in the clock domain. Each completed write gives the internal logic exactly one single-cycle pulse, together with the byte and the data/command flag.

For reads, the block samples an internal read port when the access begins. It drives that byte onto the bus through an output enable until the strobe is released. The data bus appears on the block as an input vector, an output vector and an output enable. The pad that joins them sits outside.

Top module: `mpu_bus_if`

## Requirements
- R1: The block counts as selected only when `sel_lo_n_i` is 0 and `sel_hi_i` is 1. In the other three combinations, no write pulse is produced and `bus_d_oe` stays 0.
- R2: With `addr_dc_i` = 1 the written byte is display data (`wr_is_data_o` = 1). With `addr_dc_i` = 0 it is a command (`wr_is_data_o` = 0).
- R3: In split-strobe mode (`bus_mode_i` = 0), `dir_wrn_i` is an active-low write strobe. The byte presented on `bus_d_i` while the strobe is low, and still present at its rising edge, is the one delivered.
- R4: In split-strobe mode, `stb_rdn_i` is an active-low read strobe. `bus_d_oe` is 1 while it is low and the block is selected. `bus_d_o` reads 0 whenever `bus_d_oe` is 0.
- R5: In enable-strobe mode (`bus_mode_i` = 1), `dir_wrn_i` = 0 marks a write. The byte is delivered after the falling edge of `stb_rdn_i`, which acts as the active-high enable.
- R6: In enable-strobe mode, `bus_d_oe` is 1 while the enable is high and `dir_wrn_i` = 1 (read).
- R7: Each completed write produces exactly one `wr_stb_o` pulse, one clock cycle long.
- R8: With the default two synchronizer stages, results appear at fixed clock edges. `wr_stb_o` is high for the cycle that starts at the third rising clock edge after the strobe release. `bus_d_oe` rises at the third edge after the read strobe starts and falls at the third edge after it ends.
- R9: `bus_d_o` carries the value `rd_data_i` had when the read began. It stays unchanged for the whole read even if `rd_data_i` changes.
- R10: `rst_n` = 0 sampled at a clock edge clears `wr_stb_o`, `bus_d_oe`, `wr_byte_o` and `wr_is_data_o`.
- R11: A write whose chip select is withdrawn before the write strobe is released produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_mode_i | input | 1 | Static timing style: 0 split-strobe, 1 enable-strobe |
| sel_lo_n_i | input | 1 | Active-low chip select |
| sel_hi_i | input | 1 | Active-high chip select |
| addr_dc_i | input | 1 | 1 display data, 0 command |
| dir_wrn_i | input | 1 | Write strobe (split) or direction, 1 read (enable) |
| stb_rdn_i | input | 1 | Read strobe (split) or enable, active high (enable) |
| bus_d_i | input | 8 | Data bus as seen at the pad |
| bus_d_o | output | 8 | Read data toward the pad |
| bus_d_oe | output | 1 | Pad output enable |
| rd_data_i | input | 8 | Internal byte offered to reads |
| wr_stb_o | output | 1 | One-cycle pulse per completed write |
| wr_is_data_o | output | 1 | Flag of the delivered byte |
| wr_byte_o | output | 8 | Delivered byte |

## Verification
Every result is due a fixed number of rising edges after the bus pin that causes it. The two synchronizer flops and one output register place the write pulse, and each edge of the output enable, on the third rising clock edge after the pin changed.

The bench drives pins two time units after a rising edge. It then samples exactly two and three cycles later, so it sees the output both before and on its due edge. One cycle later it confirms that the write pulse has dropped.

Counts of pulses and enabled cycles are taken on falling edges. These counts are compared only after the transfer has fully settled, which catches pulses that are missing or come twice.

// File: rtl/mpu_bus_pkg.sv
// Package: shared types for the host bus front end.
// Assumes nothing beyond the encodings defined here.
package mpu_bus_pkg;

    // Timing style of the host bus, set by a static pin.
    typedef enum logic {
        MODE_SPLIT  = 1'b0,   // separate active-low read and write strobes
        MODE_ENABLE = 1'b1    // direction level plus active-high enable
    } bus_mode_e;

    // Control pins after synchronization.
    typedef struct packed {
        logic sel_lo_n;
        logic sel_hi;
        logic addr_dc;
        logic dir_wrn;
        logic stb_rdn;
    } ctrl_pins_t;

    localparam int CTRL_W = $bits(ctrl_pins_t);

endpackage

// File: rtl/mpu_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is independently asynchronous. The reset value 0 is
// chosen so that the synchronized chip selects read as "not selected".
module mpu_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Purpose: first capture of the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_i;
            end
        end else begin : g_next
            // Purpose: further settling stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/mpu_strobe_decode.sv
// Module: combinational decode of the synchronized control pins into
// selection, write-phase and read-phase conditions for both bus styles.
// Assumes the mode input is static while the block is selected.
module mpu_strobe_decode
    import mpu_bus_pkg::*;
(
    input  logic mode_i,
    input  logic sel_lo_n_i,
    input  logic sel_hi_i,
    input  logic dir_wrn_i,
    input  logic stb_rdn_i,
    output logic sel_o,
    output logic wr_on_o,
    output logic wr_level_o,
    output logic rd_on_o
);

    bus_mode_e mode;

    assign mode  = bus_mode_e'(mode_i);
    assign sel_o = !sel_lo_n_i && sel_hi_i;

    // Purpose: map the two pins onto write/read phases per bus style.
    always_comb begin
        if (mode == MODE_SPLIT) begin
            wr_level_o = !dir_wrn_i;
            wr_on_o    = sel_o && !dir_wrn_i;
            rd_on_o    = sel_o && !stb_rdn_i;
        end else begin
            wr_level_o = stb_rdn_i;
            wr_on_o    = sel_o && stb_rdn_i && !dir_wrn_i;
            rd_on_o    = sel_o && stb_rdn_i && dir_wrn_i;
        end
    end

endmodule

// File: rtl/mpu_write_capture.sv
// Module: tracks a write phase and, when its strobe ends while still
// selected, emits one pulse with the byte and flag held during the phase.
// Assumes the byte and flag are stable for the last cycle of the phase.
module mpu_write_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_on_i,
    input  logic              wr_level_i,
    input  logic              dc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              stb_o,
    output logic              dc_o,
    output logic [DATA_W-1:0] byte_o
);

    logic              pend_q;
    logic              hold_dc_q;
    logic [DATA_W-1:0] hold_byte_q;
    logic              done;

    assign done = pend_q && sel_i && !wr_level_i;

    // Purpose: remember an open write; losing the select aborts it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= sel_i && (wr_on_i || (pend_q && wr_level_i));
    end

    // Purpose: keep the latest byte and flag seen during the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_dc_q   <= 1'b0;
            hold_byte_q <= '0;
        end else if (wr_on_i) begin
            hold_dc_q   <= dc_i;
            hold_byte_q <= data_i;
        end
    end

    // Purpose: present the completed write for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_o  <= 1'b0;
            dc_o   <= 1'b0;
            byte_o <= '0;
        end else begin
            stb_o <= done;
            if (done) begin
                dc_o   <= hold_dc_q;
                byte_o <= hold_byte_q;
            end
        end
    end

endmodule

// File: rtl/mpu_read_drive.sv
// Module: drives read data while a read phase lasts, sampling the
// internal port once when the phase begins.
// Assumes the internal port is valid at the start of the phase.
module mpu_read_drive #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_on_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              oe_o,
    output logic [DATA_W-1:0] dout_o
);

    logic              oe_q;
    logic [DATA_W-1:0] snap_q;

    // Purpose: follow the read phase and take a snapshot at its start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            snap_q <= '0;
        end else begin
            oe_q <= rd_on_i;
            if (rd_on_i && !oe_q) snap_q <= rd_data_i;
        end
    end

    assign oe_o   = oe_q;
    assign dout_o = oe_q ? snap_q : '0;

endmodule

// File: rtl/mpu_bus_if.sv
// Module: top of the dual-style host bus front end.
// Assumes all bus pins are asynchronous and bus_mode_i is static.
// Latency from a pin to a result is SYNC_STAGES + 1 clock edges.
module mpu_bus_if
    import mpu_bus_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_mode_i,
    input  logic              sel_lo_n_i,
    input  logic              sel_hi_i,
    input  logic              addr_dc_i,
    input  logic              dir_wrn_i,
    input  logic              stb_rdn_i,
    input  logic [DATA_W-1:0] bus_d_i,
    output logic [DATA_W-1:0] bus_d_o,
    output logic              bus_d_oe,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_stb_o,
    output logic              wr_is_data_o,
    output logic [DATA_W-1:0] wr_byte_o
);

    localparam int PIN_W = CTRL_W + DATA_W;

    ctrl_pins_t        raw_ctrl;
    ctrl_pins_t        syn_ctrl;
    logic [DATA_W-1:0] syn_data;
    logic              sel;
    logic              wr_on;
    logic              wr_level;
    logic              rd_on;

    assign raw_ctrl = '{sel_lo_n: sel_lo_n_i, sel_hi: sel_hi_i,
                        addr_dc: addr_dc_i, dir_wrn: dir_wrn_i,
                        stb_rdn: stb_rdn_i};

    mpu_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({raw_ctrl, bus_d_i}),
        .q_o   ({syn_ctrl, syn_data})
    );

    mpu_strobe_decode u_decode (
        .mode_i     (bus_mode_i),
        .sel_lo_n_i (syn_ctrl.sel_lo_n),
        .sel_hi_i   (syn_ctrl.sel_hi),
        .dir_wrn_i  (syn_ctrl.dir_wrn),
        .stb_rdn_i  (syn_ctrl.stb_rdn),
        .sel_o      (sel),
        .wr_on_o    (wr_on),
        .wr_level_o (wr_level),
        .rd_on_o    (rd_on)
    );

    mpu_write_capture #(.DATA_W(DATA_W)) u_write (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel),
        .wr_on_i    (wr_on),
        .wr_level_i (wr_level),
        .dc_i       (syn_ctrl.addr_dc),
        .data_i     (syn_data),
        .stb_o      (wr_stb_o),
        .dc_o       (wr_is_data_o),
        .byte_o     (wr_byte_o)
    );

    mpu_read_drive #(.DATA_W(DATA_W)) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_on_i   (rd_on),
        .rd_data_i (rd_data_i),
        .oe_o      (bus_d_oe),
        .dout_o    (bus_d_o)
    );

endmodule

// File: rtl/mpu_bus_if_checker.sv
// Module: property checker for mpu_bus_if, attached by bind.
// Assumes the default of two synchronizer stages (three-edge latency).
module mpu_bus_if_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_lo_n_i,
    input logic              sel_hi_i,
    input logic              wr_stb_o,
    input logic              bus_d_oe,
    input logic [DATA_W-1:0] bus_d_o
);

    logic rst_prev_q;

    // Purpose: remember whether reset was applied at the previous edge.
    always_ff @(posedge clk) rst_prev_q <= !rst_n;

    // R1: a deselected pin state seen three edges ago allows no output enable.
    a_r1_no_drive_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$past(sel_lo_n_i, 3) && $past(sel_hi_i, 3)) |-> !bus_d_oe);

    // R1: a deselected pin state seen three edges ago allows no write pulse.
    a_r1_no_pulse_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$past(sel_lo_n_i, 3) && $past(sel_hi_i, 3)) |-> !wr_stb_o);

    // R7: the write pulse lasts one cycle.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // R9: the driven byte does not change during a read.
    a_r9_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_d_oe && $past(bus_d_oe)) |-> $stable(bus_d_o));

    // R10: outputs are quiet after a reset edge.
    always @(posedge clk) begin
        if (rst_prev_q) begin
            a_r10_reset_quiet: assert (!bus_d_oe && !wr_stb_o);
        end
    end

endmodule

bind mpu_bus_if mpu_bus_if_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_lo_n_i (sel_lo_n_i),
    .sel_hi_i   (sel_hi_i),
    .wr_stb_o   (wr_stb_o),
    .bus_d_oe   (bus_d_oe),
    .bus_d_o    (bus_d_o)
);

// File: tb/mpu_bus_if_bench.sv
// Bench: sweeps both bus styles, all chip-select combinations and both
// address-bit values, computing expected results from the requirements.
module mpu_bus_if_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       csa_n = 1'b1;
    logic       csb = 1'b0;
    logic       adc = 1'b0;
    logic       dwr = 1'b1;
    logic       srd = 1'b1;
    logic [7:0] d_in = '0;
    logic [7:0] rd_data = '0;
    logic [7:0] d_out;
    logic       d_oe;
    logic       wstb;
    logic       wdc;
    logic [7:0] wbyte;

    int checks = 0;
    int errors = 0;
    int pulse_cnt = 0;
    int oe_cnt = 0;
    logic [7:0] last_byte = '0;
    logic       last_dc = 1'b0;
    bit done = 0;

    mpu_bus_if u_mpu_bus_if (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_mode_i   (mode),
        .sel_lo_n_i   (csa_n),
        .sel_hi_i     (csb),
        .addr_dc_i    (adc),
        .dir_wrn_i    (dwr),
        .stb_rdn_i    (srd),
        .bus_d_i      (d_in),
        .bus_d_o      (d_out),
        .bus_d_oe     (d_oe),
        .rd_data_i    (rd_data),
        .wr_stb_o     (wstb),
        .wr_is_data_o (wdc),
        .wr_byte_o    (wbyte)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count pulses and enabled cycles on falling edges.
    always @(negedge clk) begin
        if (wstb) begin
            pulse_cnt++;
            last_byte = wbyte;
            last_dc   = wdc;
        end
        if (d_oe) oe_cnt++;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_pins(input logic m);
        csa_n = 1'b1;
        csb   = 1'b0;
        dwr   = 1'b1;
        srd   = m ? 1'b0 : 1'b1;
    endtask

    task automatic do_write(input logic m, input logic a_n, input logic b,
                            input logic dc, input logic [7:0] byt);
        logic sel;
        int   c0;
        sel = !a_n && b;
        csa_n = a_n; csb = b; adc = dc; d_in = byt;
        if (m) dwr = 1'b0;
        step(2);
        c0 = pulse_cnt;
        if (m) srd = 1'b1; else dwr = 1'b0;
        step(3);
        if (m) srd = 1'b0; else dwr = 1'b1;
        step(2);
        if (sel) chk("R8 pulse not early", 32'(wstb), 32'd0);
        step(1);
        chk(m ? "R5 pulse on edge 3" : "R3 pulse on edge 3", 32'(wstb), 32'(sel));
        step(1);
        chk("R7 pulse one cycle", 32'(wstb), 32'd0);
        dwr = 1'b1;
        idle_pins(m);
        step(3);
        chk(sel ? "R7 pulse count" : "R1 no pulse when unselected",
            32'(pulse_cnt - c0), 32'(sel));
        if (sel) begin
            chk("R2 data/command flag", 32'(last_dc), 32'(dc));
            chk(m ? "R5 byte" : "R3 byte", 32'(last_byte), 32'(byt));
        end
    endtask

    task automatic do_read(input logic m, input logic a_n, input logic b,
                           input logic [7:0] val);
        logic sel;
        int   o0;
        sel = !a_n && b;
        csa_n = a_n; csb = b; rd_data = val;
        if (m) dwr = 1'b1;
        step(2);
        o0 = oe_cnt;
        if (m) srd = 1'b1; else srd = 1'b0;
        step(2);
        if (sel) chk("R8 enable not early", 32'(d_oe), 32'd0);
        step(1);
        chk(m ? "R6 enable" : "R4 enable", 32'(d_oe), 32'(sel));
        chk(m ? "R6 read byte" : "R4 read byte", 32'(d_out), sel ? 32'(val) : 32'd0);
        rd_data = ~val;
        step(2);
        chk("R9 read byte held", 32'(d_out), sel ? 32'(val) : 32'd0);
        if (m) srd = 1'b0; else srd = 1'b1;
        step(2);
        if (sel) chk("R8 enable held to edge 3", 32'(d_oe), 32'd1);
        step(1);
        chk(m ? "R6 enable released" : "R4 enable released", 32'(d_oe), 32'd0);
        idle_pins(m);
        step(3);
        if (!sel) chk("R1 no drive when unselected", 32'(oe_cnt - o0), 32'd0);
    endtask

    task automatic do_abort(input logic m);
        int c0;
        csa_n = 1'b0; csb = 1'b1; adc = 1'b1; d_in = 8'hA5;
        if (m) dwr = 1'b0;
        step(2);
        c0 = pulse_cnt;
        if (m) srd = 1'b1; else dwr = 1'b0;
        step(3);
        csa_n = 1'b1;
        step(3);
        if (m) srd = 1'b0; else dwr = 1'b1;
        step(6);
        chk("R11 aborted write gives no pulse", 32'(pulse_cnt - c0), 32'd0);
        idle_pins(m);
        step(2);
    endtask

    initial begin
        idle_pins(1'b0);
        step(4);
        chk("R10 enable after reset", 32'(d_oe), 32'd0);
        chk("R10 pulse after reset", 32'(wstb), 32'd0);
        chk("R10 byte after reset", 32'(wbyte), 32'd0);
        chk("R10 flag after reset", 32'(wdc), 32'd0);
        rst_n = 1'b1;
        step(3);

        for (int m = 0; m < 2; m++) begin
            mode = m[0];
            idle_pins(m[0]);
            step(4);
            for (int c = 0; c < 4; c++) begin
                for (int d = 0; d < 2; d++) begin
                    do_write(m[0], c[1], c[0], d[0], 8'((m * 8 + c * 2 + d) * 37 + 5));
                end
                do_read(m[0], c[1], c[0], 8'((m * 4 + c) * 53 + 17));
            end
            do_abort(m[0]);
        end

        // R10: reset in the middle of a read removes the drive at the next edge.
        mode = 1'b0;
        idle_pins(1'b0);
        step(4);
        csa_n = 1'b0; csb = 1'b1; rd_data = 8'h3C;
        step(2);
        srd = 1'b0;
        step(4);
        chk("R4 enable before reset", 32'(d_oe), 32'd1);
        rst_n = 1'b0;
        step(1);
        chk("R10 enable cleared by reset", 32'(d_oe), 32'd0);
        chk("R10 byte cleared by reset", 32'(wbyte), 32'd0);
        rst_n = 1'b1;
        idle_pins(1'b0);
        step(5);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule